// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Block

This block keeps running statistics for a 10/100 Ethernet MAC. Once per completed frame the MAC presents a one-cycle event carrying the frame length in bytes, a good flag, broadcast and multicast flags, and a vector of error-class flags. Frame parsing, CRC checking and descriptor handling happen elsewhere. This block only counts their results. It keeps a byte total, a good-frame total, broadcast and multicast totals, a six-bin length histogram of good frames, and ten error or miss counters. All counters are `CNT_W` bits wide and wrap to zero.

Each counter that wraps latches its own bit in a status register. Five further receive events set status bits directly: FIFO overflow, frame truncated for lack of a descriptor, readable frame received, receive stopped, and fatal bus error. Software writes a mask register. The registered active-low interrupt line is low whenever a status bit and its mask bit are both set. A flat word-addressed read/write port exposes the counters, the status register and the mask register.

Top module: `mac_stat_counters`

## Requirements
- R1: After reset every counter, the status register and the mask register read 0, and `irq_n` is 1.
- R2: A frame event with the good flag set adds `frm_len` to the byte counter (address 0) and adds 1 to the good-frame counter (address 1), both in one cycle. A frame event without the good flag changes neither counter.
- R3: A good frame with `frm_bcast` set adds 1 to address 2. A good frame with `frm_mcast` set adds 1 to address 3. Frames that are not good leave both counters unchanged.
- R4: A good frame falls into at most one length bin: 64 bytes goes to address 4, 65–127 to address 5, 128–255 to address 6, 256–511 to address 7, 512–1023 to address 8, and 1024–`MAX_LEN` to address 9. Good frames shorter than 64 or longer than `MAX_LEN`, and every frame that is not good, go into no bin.
- R5: Each bit k of `frm_err` adds 1 to the counter at address 10+k on a frame event, whatever the good flag. Bit 0 is pause, 1 long, 2 general receive error, 3 bad CRC, 4 misaligned, 5 undersized, 6 fragment, 7 jabber, 8 missed for no FIFO space, and 9 missed for no descriptor.
- R6: A counter that passes 2^CNT_W−1 wraps to its remainder modulo 2^CNT_W and sets status bit i, where i is the counter's address.
- R7: A 1 on `rx_evt[j]` sets status bit 20+j. The bits are 20 FIFO overflow, 21 truncated for no descriptor, 22 readable frame, 23 receive stopped, and 24 fatal bus error.
- R8: Writing the status register (address 0x20) clears each bit written as 1. If a bit is set by an event in the same cycle as its clear, the bit stays set.
- R9: The mask register (address 0x21) holds the written value. Status and mask bits 31:25 always read 0. `irq_n` is 0 exactly when (status & mask) was non-zero on the previous clock edge.
- R10: Counter i reads at address i (0–19). Writes to counter addresses are ignored, and reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle frame-complete event |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_good | input | 1 | Frame received without error |
| frm_bcast | input | 1 | Broadcast destination |
| frm_mcast | input | 1 | Multicast destination |
| frm_err | input | 10 | Error and miss class flags (see R5) |
| rx_evt | input | 5 | Non-counter receive events (see R7) |
| reg_addr | input | 7 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives good frames at each edge of the length bins: 63, 64, 127, 128, 255, 256, 511, 512, 1023, 1024, `MAX_LEN` and `MAX_LEN`+1. A design with an off-by-one comparison would put one of these frames into the wrong bin, or into a bin when it should go into none. A counter is run up to exactly one below its wrap point and then one step further. This catches a status bit that sets early or late, and a counter that saturates instead of wrapping. The bench also issues an event and its status clear in the same cycle. A design with clear priority would lose that event. Finally, `irq_n` is sampled both one and two edges after a mask or status change, which exposes a combinational interrupt path or a path with an extra register stage.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
    localparam int NUM_CNT  = 20;
    localparam int NUM_BIN  = 6;
    localparam int NUM_ERR  = 10;
    localparam int NUM_EVT  = 5;
    localparam int BIN_BASE = 4;
    localparam int ERR_BASE = 10;
    localparam int EVT_BASE = 20;
    localparam int ADDR_W   = 7;
    localparam int REG_W    = 32;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h20;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 7'h21;
    localparam logic [REG_W-1:0]  LIVE_BITS = REG_W'((64'd1 << (EVT_BASE + NUM_EVT)) - 64'd1);

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] mask;
        logic             irq_n;
    } ctl_state_t;
endpackage

// File: rtl/mac_stat_bin_sel.sv
module mac_stat_bin_sel #(
    parameter int LEN_W   = 11,
    parameter int MAX_LEN = 1518
) (
    input  logic                                frm_valid,
    input  logic                                frm_good,
    input  logic [LEN_W-1:0]                    frm_len,
    output logic [mac_stat_pkg::NUM_BIN-1:0]    bin_hit
);
    localparam logic [LEN_W-1:0] L64   = LEN_W'(64);
    localparam logic [LEN_W-1:0] L127  = LEN_W'(127);
    localparam logic [LEN_W-1:0] L255  = LEN_W'(255);
    localparam logic [LEN_W-1:0] L511  = LEN_W'(511);
    localparam logic [LEN_W-1:0] L1023 = LEN_W'(1023);
    localparam logic [LEN_W-1:0] LMAX  = LEN_W'(MAX_LEN);

    always_comb begin
        bin_hit = '0;
        if (frm_valid && frm_good) begin
            if (frm_len == L64)                         bin_hit[0] = 1'b1;
            else if (frm_len > L64   && frm_len <= L127)  bin_hit[1] = 1'b1;
            else if (frm_len > L127  && frm_len <= L255)  bin_hit[2] = 1'b1;
            else if (frm_len > L255  && frm_len <= L511)  bin_hit[3] = 1'b1;
            else if (frm_len > L511  && frm_len <= L1023) bin_hit[4] = 1'b1;
            else if (frm_len > L1023 && frm_len <= LMAX)  bin_hit[5] = 1'b1;
        end
    end
endmodule

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [AMT_W-1:0] inc_amt,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc_amt);
        cnt_d = cnt_q;
        ovf   = 1'b0;
        if (inc_en) begin
            cnt_d = sum[CNT_W-1:0];
            ovf   = sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mac_stat_counters.sv
module mac_stat_counters
    import mac_stat_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LEN_W   = 11,
    parameter int MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_good,
    input  logic              frm_bcast,
    input  logic              frm_mcast,
    input  logic [9:0]        frm_err,
    input  logic [4:0]        rx_evt,
    input  logic [6:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_n
);
    logic [NUM_BIN-1:0] bin_hit;
    logic [NUM_CNT-1:0] inc_en;
    logic [LEN_W-1:0]   inc_amt [NUM_CNT];
    logic [CNT_W-1:0]   cnt     [NUM_CNT];
    logic [NUM_CNT-1:0] ovf;
    logic [REG_W-1:0]   set_bits, clr_bits;
    ctl_state_t         st_d, st_q;

    mac_stat_bin_sel #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_bins (
        .frm_valid (frm_valid),
        .frm_good  (frm_good),
        .frm_len   (frm_len),
        .bin_hit   (bin_hit)
    );

    // Increment sources: totals, histogram, error classes
    always_comb begin
        inc_en = '0;
        for (int i = 0; i < NUM_CNT; i++) inc_amt[i] = LEN_W'(1);
        inc_amt[0] = frm_len;
        inc_en[0]  = frm_valid && frm_good;
        inc_en[1]  = frm_valid && frm_good;
        inc_en[2]  = frm_valid && frm_good && frm_bcast;
        inc_en[3]  = frm_valid && frm_good && frm_mcast;
        inc_en[BIN_BASE +: NUM_BIN] = bin_hit;
        inc_en[ERR_BASE +: NUM_ERR] = frm_valid ? frm_err : '0;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
        mac_stat_ctr #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_en  (inc_en[g]),
            .inc_amt (inc_amt[g]),
            .cnt     (cnt[g]),
            .ovf     (ovf[g])
        );
    end

    // Control state next values
    always_comb begin
        set_bits = '0;
        set_bits[NUM_CNT-1:0]          = ovf;
        set_bits[EVT_BASE +: NUM_EVT]  = rx_evt;
        clr_bits = (reg_wr && reg_addr == STAT_ADDR) ? reg_wdata : '0;

        st_d        = st_q;
        st_d.status = ((st_q.status & ~clr_bits) | set_bits) & LIVE_BITS;
        if (reg_wr && reg_addr == MASK_ADDR)
            st_d.mask = reg_wdata & LIVE_BITS;
        st_d.irq_n  = ~|(st_q.status & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '0;
            st_q.irq_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = REG_W'(cnt[i]);
        if (reg_addr == STAT_ADDR) reg_rdata = st_q.status;
        if (reg_addr == MASK_ADDR) reg_rdata = st_q.mask;
    end

    assign irq_n = st_q.irq_n;
endmodule

// File: rtl/mac_stat_chk.sv
module mac_stat_chk
    import mac_stat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [REG_W-1:0]   status,
    input logic [REG_W-1:0]   mask,
    input logic               irq_n,
    input logic [NUM_EVT-1:0] rx_evt,
    input logic [NUM_CNT-1:0] ovf,
    input logic [NUM_BIN-1:0] bin_hit
);
    assert_one_bin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bin_hit));

    assert_wrap_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((status[NUM_CNT-1:0] & $past(ovf)) == $past(ovf)));

    assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_evt) |=> ((status[EVT_BASE +: NUM_EVT] & $past(rx_evt)) == $past(rx_evt)));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[REG_W-1:EVT_BASE+NUM_EVT] == '0) && (mask[REG_W-1:EVT_BASE+NUM_EVT] == '0));

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) != '0) |=> !irq_n);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == '0) |=> irq_n);
endmodule

bind mac_stat_counters mac_stat_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (st_q.status),
    .mask    (st_q.mask),
    .irq_n   (irq_n),
    .rx_evt  (rx_evt),
    .ovf     (ovf),
    .bin_hit (bin_hit)
);

// File: tb/mac_stat_counters_tb.sv
module mac_stat_counters_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 12;
    localparam int TB_LEN_W   = 11;
    localparam int TB_MAX     = 1518;
    localparam int CNT_MOD    = 1 << TB_CNT_W;
    localparam int NONE       = 7;

    // Vector: [15] good, [14:12] expected bin (7 = none), [10:0] length
    localparam logic [15:0] VEC [14] = '{
        {1'b1, 3'd0, 1'b0, 11'd64},   {1'b1, 3'd7, 1'b0, 11'd63},
        {1'b1, 3'd1, 1'b0, 11'd65},   {1'b1, 3'd1, 1'b0, 11'd127},
        {1'b1, 3'd2, 1'b0, 11'd128},  {1'b1, 3'd2, 1'b0, 11'd255},
        {1'b1, 3'd3, 1'b0, 11'd256},  {1'b1, 3'd3, 1'b0, 11'd511},
        {1'b1, 3'd4, 1'b0, 11'd512},  {1'b1, 3'd4, 1'b0, 11'd1023},
        {1'b1, 3'd5, 1'b0, 11'd1024}, {1'b1, 3'd5, 1'b0, 11'd1518},
        {1'b1, 3'd7, 1'b0, 11'd1519}, {1'b0, 3'd7, 1'b0, 11'd300}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_valid = 0, frm_good = 0, frm_bcast = 0, frm_mcast = 0;
    logic [TB_LEN_W-1:0] frm_len = '0;
    logic [9:0]  frm_err = '0;
    logic [4:0]  rx_evt = '0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_n;

    int n_tests = 0, n_fail = 0;
    int exp_cnt [20];
    logic [31:0] exp_stat = '0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_stat_counters #(.CNT_W(TB_CNT_W), .LEN_W(TB_LEN_W), .MAX_LEN(TB_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_good(frm_good), .frm_bcast(frm_bcast), .frm_mcast(frm_mcast),
        .frm_err(frm_err), .rx_evt(rx_evt), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic model_add(input int i, input int amt);
        int v;
        v = exp_cnt[i] + amt;
        if (v >= CNT_MOD) begin
            v = v - CNT_MOD;
            exp_stat[i] = 1'b1;
        end
        exp_cnt[i] = v;
    endtask

    task automatic send_frame(input int len, input logic good, input logic bc,
                              input logic mc, input logic [9:0] err, input int bin);
        @(negedge clk);
        frm_valid = 1; frm_len = TB_LEN_W'(len); frm_good = good;
        frm_bcast = bc; frm_mcast = mc; frm_err = err;
        @(negedge clk);
        frm_valid = 0; frm_good = 0; frm_bcast = 0; frm_mcast = 0; frm_err = '0;
        if (good) begin
            model_add(0, len);
            model_add(1, 1);
            if (bc) model_add(2, 1);
            if (mc) model_add(3, 1);
            if (bin != NONE) model_add(4 + bin, 1);
        end
        for (int k = 0; k < 10; k++) if (err[k]) model_add(10 + k, 1);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 20; i++) exp_cnt[i] = 0;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(7'd0, rv);  chk("R1 byte counter", rv, 0);
        rd(7'd13, rv); chk("R1 crc counter", rv, 0);
        rd(7'h20, rv); chk("R1 status", rv, 0);
        rd(7'h21, rv); chk("R1 mask", rv, 0);
        chk("R1 irq_n", {31'd0, irq_n}, 1);

        // R4 / R2 histogram table walk
        for (int v = 0; v < 14; v++) begin
            send_frame(int'(VEC[v][10:0]), VEC[v][15], 0, 0, '0, int'(VEC[v][14:12]));
            for (int b = 0; b < 6; b++) begin
                rd(7'(4 + b), rv);
                chk("R4 length bin", rv, 32'(exp_cnt[4 + b]));
            end
        end
        rd(7'd0, rv); chk("R2 byte total wraps by length", rv, 32'(exp_cnt[0]));
        rd(7'd1, rv); chk("R2 good frame total", rv, 32'(exp_cnt[1]));
        rd(7'h20, rv); chk("R6 byte overflow status", rv & 32'h1, exp_stat & 32'h1);

        // R3 broadcast / multicast
        send_frame(100, 1, 1, 0, '0, 1);
        send_frame(100, 0, 1, 1, '0, NONE);
        send_frame(200, 1, 0, 1, '0, 2);
        rd(7'd2, rv); chk("R3 broadcast", rv, 32'(exp_cnt[2]));
        rd(7'd3, rv); chk("R3 multicast", rv, 32'(exp_cnt[3]));

        // R5 error classes regardless of good
        send_frame(80, 0, 0, 0, 10'b00_0000_1000, NONE);
        send_frame(80, 1, 0, 0, 10'b10_0000_1000, 1);
        rd(7'd13, rv); chk("R5 crc counter", rv, 32'(exp_cnt[13]));
        rd(7'd19, rv); chk("R5 no-descriptor miss counter", rv, 32'(exp_cnt[19]));
        rd(7'd1, rv);  chk("R2 bad frame not in good total", rv, 32'(exp_cnt[1]));

        // R10 counter writes ignored, unused address reads zero
        wr(7'd13, 32'h0000_0ABC);
        rd(7'd13, rv);  chk("R10 counter write ignored", rv, 32'(exp_cnt[13]));
        rd(7'h30, rv);  chk("R10 unused address", rv, 0);

        // R6 wrap of pause counter (address 10)
        for (int n = 0; n < CNT_MOD - 1; n++) send_frame(70, 0, 0, 0, 10'b1, NONE);
        rd(7'd10, rv);  chk("R6 counter at top", rv, 32'(CNT_MOD - 1));
        rd(7'h20, rv);  chk("R6 status not yet set", (rv >> 10) & 1, 0);
        send_frame(70, 0, 0, 0, 10'b1, NONE);
        rd(7'd10, rv);  chk("R6 counter wrapped", rv, 0);
        rd(7'h20, rv);  chk("R6 status set on wrap", (rv >> 10) & 1, 1);

        // R9 mask and registered interrupt
        chk("R9 masked status no irq", {31'd0, irq_n}, 1);
        wr(7'h21, 32'h0000_0400);
        chk("R9 irq one edge late", {31'd0, irq_n}, 1);
        @(negedge clk);
        chk("R9 irq asserted", {31'd0, irq_n}, 0);
        wr(7'h21, 32'hFFFF_FFFF);
        rd(7'h21, rv); chk("R9 mask reserved bits", rv, 32'h01FF_FFFF);

        // R8 clear, R7 events
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h20, rv); chk("R8 write-one clear", rv, 0);
        chk("R9 irq still low one edge after clear", {31'd0, irq_n}, 0);
        @(negedge clk);
        chk("R9 irq released", {31'd0, irq_n}, 1);
        rx_evt = 5'h1F;
        @(negedge clk);
        rx_evt = '0;
        rd(7'h20, rv); chk("R7 event bits", rv, 32'h01F0_0000);
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h20, rv); chk("R8 cleared again", rv, 0);
        @(negedge clk);
        reg_addr = 7'h20; reg_wdata = 32'h0010_0000; reg_wr = 1; rx_evt = 5'h01;
        @(negedge clk);
        reg_wr = 0; rx_evt = '0;
        rd(7'h20, rv); chk("R8 set wins over clear", rv, 32'h0010_0000);

        summary();
        $finish;
    end
endmodule